// File: doc/BRIEF.md
# Privilege-Mode Address Segment Decoder

This block is placed ahead of the translation lookaside buffer. For every virtual address it reads the processor privilege field and the two exception-level status bits, then sorts the access into one of three outcomes. The access is either an address error, reported separately for loads and for stores, or a direct translation inside one of two fixed kernel windows, or a mapped access that is passed to the TLB.

The two kernel windows need no table. Each one is translated by subtracting the window base from the virtual address. The lower window is cacheable and the upper window is uncached. The windows are selected by the top three address bits, so the address width is a parameter. An optional output register stage, chosen by a parameter, either returns the verdict in the same cycle as the request strobe or returns it one clock later from reset-cleared flops.

Top module: `privseg_decoder`

## Requirements
- R1: When `erl` or `exl` is 1, the access is decoded as kernel mode whatever the value of `ksu`, so it never raises an address error.
- R2: The `ksu` encoding is 2'b00 kernel, 2'b01 supervisor and 2'b10 user. The reserved value 2'b11 is decoded as kernel.
- R3: In kernel mode, an address whose top three bits are 3'b100 (0x80000000 to 0x9FFFFFFF at 32 bits) asserts `direct_done` with `uncached`=0, keeps `tlb_req` low, and gives `paddr` = vaddr − 0x80000000.
- R4: In kernel mode, an address whose top three bits are 3'b101 (0xA0000000 to 0xBFFFFFFF) asserts `direct_done` with `uncached`=1, keeps `tlb_req` low, and gives `paddr` = vaddr − 0xA0000000.
- R5: In supervisor mode, an address is legal only when its top three bits are 3'b000 or 3'b110. Any other address is an address error.
- R6: In user mode, any address with its most significant bit set is an address error.
- R7: An address error raises `ld_addr_err` when `is_store`=0 and `st_addr_err` when `is_store`=1, never both.
- R8: Every legal address outside the two kernel windows asserts `tlb_req`, with `paddr`=0 and `uncached`=0.
- R9: For each request with `req_valid`=1, exactly one of `ld_addr_err`, `st_addr_err`, `direct_done` and `tlb_req` is 1. With `req_valid`=0, every output is 0.
- R10: With `OUT_REG`=1 (the default), the verdict appears one clock after the request, and all outputs are 0 while `rst_n` is low. With `OUT_REG`=0, the verdict appears in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| ksu | input | 2 | Privilege field |
| erl | input | 1 | Error-level status bit |
| exl | input | 1 | Exception-level status bit |
| vaddr | input | ADDR_W | Virtual address |
| is_store | input | 1 | 1 for a store, 0 for a load |
| paddr | output | ADDR_W | Physical address for direct windows, else 0 |
| uncached | output | 1 | Direct access is uncached |
| tlb_req | output | 1 | Access must be mapped by the TLB |
| direct_done | output | 1 | Direct translation completed |
| ld_addr_err | output | 1 | Address error on a load |
| st_addr_err | output | 1 | Address error on a store |

## Verification
The bench builds two copies side by side, both with `ADDR_W`=32. One keeps the default `OUT_REG`=1 and the other sets `OUT_REG`=0. Both copies receive the same stimulus. This makes it possible to compare the same-cycle direct-completion path against the one-clock registered path, and to check the cleared outputs during reset. The address width of 32 places the window boundaries at the familiar 0x80000000, 0xA0000000, 0xC0000000 and 0xE0000000 edges. The bench drives these edges directly in every privilege state and for both access directions.

// File: rtl/privseg_pkg.sv
package privseg_pkg;

   typedef enum logic [1:0] {
      PRIV_KERNEL = 2'd0,
      PRIV_SUPER  = 2'd1,
      PRIV_USER   = 2'd2
   } priv_e;

   typedef struct packed {
      logic ld_err;
      logic st_err;
      logic direct;
      logic tlb;
      logic uncached;
   } verdict_t;

   // Segment selectors taken from the top three address bits
   localparam logic [2:0] SEG_LOW      = 3'b000;
   localparam logic [2:0] SEG_DIRECT   = 3'b100;
   localparam logic [2:0] SEG_UNCACHED = 3'b101;
   localparam logic [2:0] SEG_SUPER_HI = 3'b110;

endpackage

// File: rtl/privseg_priv_resolve.sv
module privseg_priv_resolve
   import privseg_pkg::*;
(
   input  logic [1:0] ksu_i,
   input  logic       erl_i,
   input  logic       exl_i,
   output priv_e      priv_o
);

   always_comb begin
      case (ksu_i)
         2'b01:   priv_o = PRIV_SUPER;
         2'b10:   priv_o = PRIV_USER;
         default: priv_o = PRIV_KERNEL;   // 00 and the reserved 11
      endcase
      // exception levels force kernel privilege
      if (erl_i || exl_i) priv_o = PRIV_KERNEL;
   end

endmodule

// File: rtl/privseg_seg_classify.sv
module privseg_seg_classify
   import privseg_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              valid_i,
   input  priv_e             priv_i,
   input  logic [ADDR_W-1:0] va_i,
   input  logic              store_i,
   output verdict_t          verdict_o,
   output logic [ADDR_W-1:0] pa_o
);

   localparam int SEL_LSB = ADDR_W - 3;
   localparam logic [ADDR_W-1:0] BASE_DIRECT   = {SEG_DIRECT,   {SEL_LSB{1'b0}}};
   localparam logic [ADDR_W-1:0] BASE_UNCACHED = {SEG_UNCACHED, {SEL_LSB{1'b0}}};

   logic [2:0] sel;
   logic       legal;
   logic       hit_direct;
   logic       hit_uncached;

   assign sel = va_i[ADDR_W-1 -: 3];

   always_comb begin
      case (priv_i)
         PRIV_KERNEL: legal = 1'b1;
         PRIV_SUPER:  legal = (sel == SEG_LOW) || (sel == SEG_SUPER_HI);
         PRIV_USER:   legal = !va_i[ADDR_W-1];
         default:     legal = 1'b0;
      endcase
      hit_direct   = (priv_i == PRIV_KERNEL) && (sel == SEG_DIRECT);
      hit_uncached = (priv_i == PRIV_KERNEL) && (sel == SEG_UNCACHED);
   end

   always_comb begin
      verdict_o = '0;
      pa_o      = '0;
      if (valid_i) begin
         if (!legal) begin
            verdict_o.ld_err = !store_i;
            verdict_o.st_err = store_i;
         end else if (hit_direct) begin
            verdict_o.direct = 1'b1;
            pa_o             = va_i - BASE_DIRECT;
         end else if (hit_uncached) begin
            verdict_o.direct   = 1'b1;
            verdict_o.uncached = 1'b1;
            pa_o               = va_i - BASE_UNCACHED;
         end else begin
            verdict_o.tlb = 1'b1;
         end
      end
   end

endmodule

// File: rtl/privseg_out_stage.sv
module privseg_out_stage
   import privseg_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  verdict_t          verdict_i,
   input  logic [ADDR_W-1:0] pa_i,
   output verdict_t          verdict_o,
   output logic [ADDR_W-1:0] pa_o
);

   generate
      if (OUT_REG == 0) begin : g_pass
         assign verdict_o = verdict_i;
         assign pa_o      = pa_i;
      end else begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               verdict_o <= '0;
               pa_o      <= '0;
            end else begin
               verdict_o <= verdict_i;
               pa_o      <= pa_i;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/privseg_decoder.sv
module privseg_decoder
   import privseg_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        ksu,
   input  logic              erl,
   input  logic              exl,
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              is_store,
   output logic [ADDR_W-1:0] paddr,
   output logic              uncached,
   output logic              tlb_req,
   output logic              direct_done,
   output logic              ld_addr_err,
   output logic              st_addr_err
);

   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("privseg_decoder: ADDR_W must be at least 8");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
         $error("privseg_decoder: OUT_REG must be 0 or 1");
      end
   endgenerate

   priv_e             priv;
   verdict_t          v_raw;
   verdict_t          v_out;
   logic [ADDR_W-1:0] pa_raw;

   privseg_priv_resolve u_priv (
      .ksu_i  (ksu),
      .erl_i  (erl),
      .exl_i  (exl),
      .priv_o (priv)
   );

   privseg_seg_classify #(.ADDR_W(ADDR_W)) u_class (
      .valid_i   (req_valid),
      .priv_i    (priv),
      .va_i      (vaddr),
      .store_i   (is_store),
      .verdict_o (v_raw),
      .pa_o      (pa_raw)
   );

   privseg_out_stage #(.ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .verdict_i (v_raw),
      .pa_i      (pa_raw),
      .verdict_o (v_out),
      .pa_o      (paddr)
   );

   assign ld_addr_err = v_out.ld_err;
   assign st_addr_err = v_out.st_err;
   assign direct_done = v_out.direct;
   assign tlb_req     = v_out.tlb;
   assign uncached    = v_out.uncached;

endmodule

// File: rtl/privseg_decoder_chk.sv
module privseg_decoder_chk #(
   parameter int ADDR_W  = 32,
   parameter int OUT_REG = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        ksu,
   input logic              erl,
   input logic              exl,
   input logic [ADDR_W-1:0] vaddr,
   input logic              is_store,
   input logic [ADDR_W-1:0] paddr,
   input logic              uncached,
   input logic              tlb_req,
   input logic              direct_done,
   input logic              ld_addr_err,
   input logic              st_addr_err
);

   localparam logic [ADDR_W-1:0] BASE0 = {3'b100, {(ADDR_W-3){1'b0}}};
   localparam logic [ADDR_W-1:0] BASE1 = {3'b101, {(ADDR_W-3){1'b0}}};

   logic              e_valid;
   logic [1:0]        e_ksu;
   logic              e_erl;
   logic              e_exl;
   logic [ADDR_W-1:0] e_va;
   logic              e_store;

   generate
      if (OUT_REG == 0) begin : g_now
         assign e_valid = req_valid;
         assign e_ksu   = ksu;
         assign e_erl   = erl;
         assign e_exl   = exl;
         assign e_va    = vaddr;
         assign e_store = is_store;
      end else begin : g_late
         logic              armed;
         logic              d_valid;
         logic [1:0]        d_ksu;
         logic              d_erl;
         logic              d_exl;
         logic [ADDR_W-1:0] d_va;
         logic              d_store;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               armed   <= 1'b0;
               d_valid <= 1'b0;
               d_ksu   <= '0;
               d_erl   <= 1'b0;
               d_exl   <= 1'b0;
               d_va    <= '0;
               d_store <= 1'b0;
            end else begin
               armed   <= 1'b1;
               d_valid <= req_valid;
               d_ksu   <= ksu;
               d_erl   <= erl;
               d_exl   <= exl;
               d_va    <= vaddr;
               d_store <= is_store;
            end
         end
         assign e_valid = armed && d_valid;
         assign e_ksu   = d_ksu;
         assign e_erl   = d_erl;
         assign e_exl   = d_exl;
         assign e_va    = d_va;
         assign e_store = d_store;
      end
   endgenerate

   logic e_kern;
   assign e_kern = e_erl || e_exl || (e_ksu == 2'b00) || (e_ksu == 2'b11);

   // R9
   outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      e_valid |-> ($countones({ld_addr_err, st_addr_err, direct_done, tlb_req}) == 1));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !e_valid |-> !(ld_addr_err || st_addr_err || direct_done || tlb_req || uncached) && (paddr == '0));

   // R3
   kwin_cached_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid && e_kern && e_va[ADDR_W-1 -: 3] == 3'b100)
      |-> direct_done && !uncached && !tlb_req && (paddr == e_va - BASE0));

   // R4
   kwin_uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid && e_kern && e_va[ADDR_W-1 -: 3] == 3'b101)
      |-> direct_done && uncached && !tlb_req && (paddr == e_va - BASE1));

   // R1
   exc_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid && (e_erl || e_exl)) |-> !(ld_addr_err || st_addr_err));

   // R6
   user_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid && !e_erl && !e_exl && e_ksu == 2'b10 && e_va[ADDR_W-1])
      |-> (ld_addr_err || st_addr_err));

   // R7
   err_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (e_valid && (ld_addr_err || st_addr_err))
      |-> (st_addr_err == e_store) && (ld_addr_err == !e_store));

   // R8
   tlb_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req |-> !uncached && (paddr == '0));

endmodule

bind privseg_decoder privseg_decoder_chk #(.ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .ksu         (ksu),
   .erl         (erl),
   .exl         (exl),
   .vaddr       (vaddr),
   .is_store    (is_store),
   .paddr       (paddr),
   .uncached    (uncached),
   .tlb_req     (tlb_req),
   .direct_done (direct_done),
   .ld_addr_err (ld_addr_err),
   .st_addr_err (st_addr_err)
);

// File: tb/privseg_decoder_bench.sv
`timescale 1ns/1ps
module privseg_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  ksu = 2'b00;
   logic        erl = 1'b0;
   logic        exl = 1'b0;
   logic [31:0] vaddr = '0;
   logic        is_store = 1'b0;

   logic [31:0] r_pa, c_pa;
   logic        r_unc, r_tlb, r_dir, r_ld, r_st;
   logic        c_unc, c_tlb, c_dir, c_ld, c_st;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   privseg_decoder #(.ADDR_W(32), .OUT_REG(1)) u_privseg_decoder (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ksu(ksu), .erl(erl), .exl(exl),
      .vaddr(vaddr), .is_store(is_store), .paddr(r_pa), .uncached(r_unc), .tlb_req(r_tlb),
      .direct_done(r_dir), .ld_addr_err(r_ld), .st_addr_err(r_st));

   privseg_decoder #(.ADDR_W(32), .OUT_REG(0)) u_privseg_decoder_comb (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ksu(ksu), .erl(erl), .exl(exl),
      .vaddr(vaddr), .is_store(is_store), .paddr(c_pa), .uncached(c_unc), .tlb_req(c_tlb),
      .direct_done(c_dir), .ld_addr_err(c_ld), .st_addr_err(c_st));

   wire [36:0] got_r = {r_ld, r_st, r_dir, r_tlb, r_unc, r_pa};
   wire [36:0] got_c = {c_ld, c_st, c_dir, c_tlb, c_unc, c_pa};

   // bit layout: {ld_err, st_err, direct, tlb, uncached, paddr[31:0]}
   function automatic logic [36:0] ref_model(input logic v, input logic [1:0] k,
                                             input logic e1, input logic e2,
                                             input logic [31:0] a, input logic st);
      logic [36:0] r;
      logic kern, legal;
      r = '0;
      if (!v) return r;
      kern = e1 || e2 || (k == 2'b00) || (k == 2'b11);
      if (kern) legal = 1'b1;
      else if (k == 2'b01) legal = (a[31:29] == 3'b000) || (a[31:29] == 3'b110);
      else legal = !a[31];
      if (!legal) begin
         r[36] = !st;
         r[35] = st;
      end else if (a[31:29] == 3'b100) begin
         r[34] = 1'b1;
         r[31:0] = a - 32'h8000_0000;
      end else if (a[31:29] == 3'b101) begin
         r[34] = 1'b1;
         r[32] = 1'b1;
         r[31:0] = a - 32'hA000_0000;
      end else begin
         r[33] = 1'b1;
      end
      return r;
   endfunction

   function automatic string req_tag(input logic v, input logic [1:0] k,
                                     input logic e1, input logic e2, input logic [31:0] a);
      logic kern;
      if (!v) return "R9";
      kern = e1 || e2 || (k == 2'b00) || (k == 2'b11);
      if (kern && a[31:29] == 3'b100) return (e1 || e2) ? "R1 R3" : ((k == 2'b11) ? "R2 R3" : "R3");
      if (kern && a[31:29] == 3'b101) return (e1 || e2) ? "R1 R4" : ((k == 2'b11) ? "R2 R4" : "R4");
      if (kern) return (e1 || e2) ? "R1 R8" : ((k == 2'b11) ? "R2 R8" : "R8");
      if (k == 2'b01)
         return ((a[31:29] == 3'b000) || (a[31:29] == 3'b110)) ? "R5 R8" : "R5 R7 R9";
      return a[31] ? "R6 R7 R9" : "R6 R8";
   endfunction

   task automatic check(input logic [36:0] got, input logic [36:0] exp, input string tag);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic apply(input logic v, input logic [1:0] k, input logic e1, input logic e2,
                        input logic [31:0] a, input logic st);
      logic [36:0] exp;
      string tag;
      @(negedge clk);
      req_valid = v; ksu = k; erl = e1; exl = e2; vaddr = a; is_store = st;
      exp = ref_model(v, k, e1, e2, a, st);
      tag = req_tag(v, k, e1, e2, a);
      #1;
      check(got_c, exp, {tag, " R10 same-cycle"});
      @(posedge clk);
      #1;
      check(got_r, exp, {tag, " R10 registered"});
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   localparam logic [31:0] EDGES [12] = '{
      32'h0000_0000, 32'h1FFF_FFFF, 32'h2000_0000, 32'h7FFF_FFFF,
      32'h8000_0000, 32'h9FFF_FFFF, 32'hA000_0000, 32'hBFFF_FFFF,
      32'hC000_0000, 32'hDFFF_FFFF, 32'hE000_0000, 32'hFFFF_FFFF};

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got=timeout expected=completion");
      report();
   end

   initial begin
      void'($urandom(32'h0C0F_FEE5));
      // R10: registered outputs stay cleared under reset even with a live request
      @(negedge clk);
      req_valid = 1'b1; ksu = 2'b00; vaddr = 32'h8123_4567;
      repeat (2) @(posedge clk);
      #1;
      check(got_r, 37'd0, "R10 reset state");
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // directed edges in all privilege encodings (R2 R3 R4 R5 R6 R7 R8)
      for (int k = 0; k < 4; k++)
         for (int i = 0; i < 12; i++)
            for (int s = 0; s < 2; s++)
               apply(1'b1, 2'(k), 1'b0, 1'b0, EDGES[i], 1'(s));

      // R1: exception levels override supervisor and user
      for (int k = 1; k < 3; k++)
         for (int i = 0; i < 12; i++) begin
            apply(1'b1, 2'(k), 1'b1, 1'b0, EDGES[i], 1'b1);
            apply(1'b1, 2'(k), 1'b0, 1'b1, EDGES[i], 1'b0);
         end

      // R9: no strobe, no outcome
      for (int i = 0; i < 12; i++)
         apply(1'b0, 2'(i % 4), 1'b0, 1'b0, EDGES[i], 1'(i % 2));

      // constrained random mix
      for (int n = 0; n < 800; n++)
         apply(($urandom % 10) != 0, 2'($urandom_range(0, 3)),
               ($urandom % 8) == 0, ($urandom % 8) == 0,
               $urandom, 1'($urandom % 2));

      report();
   end

endmodule